// File: doc/BRIEF.md
# Periodic and Diagnostic Receive Frame Cache

This block sits between the bus-side frame FIFOs of a serial backplane interface and a local microcontroller. It pulls whole frames from the receive FIFO and sorts each one by a class flag in its header byte. Cyclic I/O refresh frames land in a periodic area that newer frames simply replace. Diagnostic frames land in a separate protected area, raise an interrupt and stay there until the microcontroller has read them.

The periodic area is double buffered. A frame is collected into the hidden bank and the banks swap only when its last byte arrives, so a read never returns a mix of two frames. In the other direction the microcontroller fills an outgoing write cache and commits it. The block then pushes the whole frame into the transmit FIFO once that FIFO reports room for all of it.

The microcontroller port is a synchronous register port. Addresses are split into four regions of one frame each. Region 0 is the periodic area, region 1 the diagnostic area, region 2 the write cache and region 3 the control words. Read data appears on the cycle after the read strobe.

Top module: `bp_frame_cache`

## Requirements
- R1: The class of a frame is bit 7 of its first (header) byte. 0 sends the frame to the periodic area at addresses 0 to 7. 1 sends it to the diagnostic area at addresses 8 to 15. Byte i of a frame sits at offset i of its area.
- R2: A periodic frame overwrites the earlier periodic frame in full. It raises no interrupt and changes no status bit. The status word is at address 24: bit 0 is diagnostic full, bit 1 is diagnostic lost, bit 2 is transmit busy.
- R3: Reads of the periodic area show only completed frames. During a frame transfer they return the previous frame. The new frame is visible from the cycle after its last byte is popped.
- R4: A diagnostic frame that arrives while the diagnostic area is empty is stored. irq goes high on the cycle after its last byte is popped.
- R5: A diagnostic frame that arrives while the diagnostic area is full is dropped. The stored frame is left unchanged and status bit 1 is set.
- R6: A read of diagnostic offset 7 (address 15) while the area is full empties it, and irq is low from the next cycle. Reads of other diagnostic offsets leave irq high.
- R7: Status bit 1 stays set until the microcontroller writes address 24 with data bit 1 equal to 1.
- R8: Writes to addresses 16 to 23 fill the write cache. Any write to address 25 commits it. Status bit 2 is set from the cycle after the commit. Once txFree has been at least 8 on some cycle, txPush is high on the 8 following cycles and carries cache bytes 0 to 7 in order. Status bit 2 then clears.
- R9: While status bit 2 is set, writes to the write cache and further commits are ignored.
- R10: When no frame is in progress, rxPop follows rxFrameRdy. A started frame is popped on 8 consecutive cycles with rxData taken in each pop cycle. Frames may follow back to back. mcuRdata is registered, and after reset all areas and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxFrameRdy | input | 1 | Receive FIFO holds a whole frame at its head |
| rxData | input | 8 | Receive FIFO head byte (first-word fall-through) |
| rxPop | output | 1 | Consume the receive FIFO head byte |
| txFree | input | 6 | Free byte slots in the transmit FIFO |
| txPush | output | 1 | Write txData into the transmit FIFO |
| txData | output | 8 | Byte pushed to the transmit FIFO |
| mcuAddr | input | 5 | Microcontroller address |
| mcuWr | input | 1 | Microcontroller write strobe |
| mcuRd | input | 1 | Microcontroller read strobe |
| mcuWdata | input | 8 | Microcontroller write data |
| mcuRdata | output | 8 | Read data, valid the cycle after mcuRd |
| irq | output | 1 | Unread diagnostic frame present |

## Verification
A wrong bank select or a swap at the wrong time shows up as mcuRdata returning part of the new frame, or a stale frame, on the very read after the last byte pops. A frame counter that is off by one shows on rxPop within one frame time, as a missing or extra pop. Faults in the diagnostic full and lost flags show on irq, or in the status word, one cycle after the frame end or the clearing read. A fault in the transmit sequencer shows on txPush and txData in the first cycle it diverges.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    TGT_PER  = 2'd0,
    TGT_DIAG = 2'd1,
    TGT_DROP = 2'd2
  } rxTarget_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_PUSH = 2'd2
  } txState_t;

  typedef enum logic [1:0] {
    REG_PER  = 2'd0,
    REG_DIAG = 2'd1,
    REG_WC   = 2'd2,
    REG_CTL  = 2'd3
  } region_t;

  // strobes from control to datapath
  typedef struct packed {
    logic backWr;
    logic diagWr;
    logic swapBank;
    logic wcWr;
    logic rdEn;
  } dpStrobe_t;

  localparam int ST_W       = 3;
  localparam int ST_DIAG    = 0;
  localparam int ST_LOST    = 1;
  localparam int ST_BUSY    = 2;
  localparam int CTL_STATUS = 0;
  localparam int CTL_COMMIT = 1;

endpackage

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int FREE_W      = 6,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxFrameRdy,
  input  logic              rxHdrClass,
  output logic              rxPop,
  output logic [IDX_W-1:0]  rxIdx,
  input  logic [FREE_W-1:0] txFree,
  output logic              txPush,
  output logic [IDX_W-1:0]  txIdx,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic              mcuWr,
  input  logic              mcuRd,
  input  logic              lostClrBit,
  output dpStrobe_t         strb,
  output logic [ST_W-1:0]   status
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FRAME_BYTES - 1);
  localparam logic [FREE_W-1:0] FRAME_CNT = FREE_W'(FRAME_BYTES);

  region_t          region;
  logic [IDX_W-1:0] offset;
  assign region = region_t'(mcuAddr[ADDR_W-1:IDX_W]);
  assign offset = mcuAddr[IDX_W-1:0];

  // receive sequencer
  logic             rxActive;
  logic [IDX_W-1:0] rxCnt;
  rxTarget_t        rxTgt, tgtNow;
  logic             rxLast;
  logic             diagFull, lostDiag;

  assign rxPop = rxActive || rxFrameRdy;
  assign rxIdx = rxActive ? rxCnt : '0;
  assign rxLast = rxPop && (rxIdx == LAST_IDX);

  always_comb begin
    if (rxActive)        tgtNow = rxTgt;
    else if (!rxHdrClass) tgtNow = TGT_PER;
    else if (diagFull)   tgtNow = TGT_DROP;
    else                 tgtNow = TGT_DIAG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
      rxTgt    <= TGT_PER;
    end else if (rxPop) begin
      rxTgt <= tgtNow;
      if (rxLast) begin
        rxActive <= 1'b0;
        rxCnt    <= '0;
      end else begin
        rxActive <= 1'b1;
        rxCnt    <= rxIdx + 1'b1;
      end
    end
  end

  // diagnostic area ownership and lost flag
  logic diagRdClr, lostWrClr;
  assign diagRdClr = mcuRd && (region == REG_DIAG) && (offset == LAST_IDX) && diagFull;
  assign lostWrClr = mcuWr && (region == REG_CTL) && (offset == IDX_W'(CTL_STATUS)) && lostClrBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      diagFull <= 1'b0;
      lostDiag <= 1'b0;
    end else begin
      if (rxLast && tgtNow == TGT_DIAG) diagFull <= 1'b1;
      else if (diagRdClr)               diagFull <= 1'b0;
      if (rxLast && tgtNow == TGT_DROP) lostDiag <= 1'b1;
      else if (lostWrClr)               lostDiag <= 1'b0;
    end
  end

  // transmit sequencer
  txState_t         txState;
  logic [IDX_W-1:0] txCnt;
  logic             txBusy, commit;

  assign txBusy = (txState != TX_IDLE);
  assign commit = mcuWr && (region == REG_CTL) && (offset == IDX_W'(CTL_COMMIT)) && !txBusy;
  assign txPush = (txState == TX_PUSH);
  assign txIdx  = txCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: if (commit) txState <= TX_WAIT;
        TX_WAIT: if (txFree >= FRAME_CNT) begin
          txState <= TX_PUSH;
          txCnt   <= '0;
        end
        TX_PUSH: begin
          if (txCnt == LAST_IDX) txState <= TX_IDLE;
          txCnt <= txCnt + 1'b1;
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.backWr   = rxPop && (tgtNow == TGT_PER);
    strb.diagWr   = rxPop && (tgtNow == TGT_DIAG);
    strb.swapBank = rxLast && (tgtNow == TGT_PER);
    strb.wcWr     = mcuWr && (region == REG_WC) && !txBusy;
    strb.rdEn     = mcuRd;
  end

  always_comb begin
    status          = '0;
    status[ST_DIAG] = diagFull;
    status[ST_LOST] = lostDiag;
    status[ST_BUSY] = txBusy;
  end

endmodule

// File: rtl/bfc_data.sv
module bfc_data
  import bfc_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  rxIdx,
  input  logic [DATA_W-1:0] rxData,
  input  logic [IDX_W-1:0]  txIdx,
  output logic [DATA_W-1:0] txData,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic [DATA_W-1:0] mcuWdata,
  input  logic [ST_W-1:0]   status,
  output logic [DATA_W-1:0] mcuRdata
);

  localparam int NUM_BANKS = 2;

  logic [DATA_W-1:0] bankMem [NUM_BANKS][FRAME_BYTES];
  logic [DATA_W-1:0] diagMem [FRAME_BYTES];
  logic [DATA_W-1:0] wcMem   [FRAME_BYTES];
  logic              frontSel, backSel;
  logic [DATA_W-1:0] rdVal;
  region_t           region;
  logic [IDX_W-1:0]  offset;

  assign backSel = ~frontSel;
  assign region  = region_t'(mcuAddr[ADDR_W-1:IDX_W]);
  assign offset  = mcuAddr[IDX_W-1:0];

  // periodic double buffer
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < FRAME_BYTES; i++) bankMem[b][i] <= '0;
        end else if (strb.backWr && (backSel == 1'(b))) begin
          bankMem[b][rxIdx] <= rxData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                frontSel <= 1'b0;
    else if (strb.swapBank) frontSel <= backSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FRAME_BYTES; i++) diagMem[i] <= '0;
    end else if (strb.diagWr) begin
      diagMem[rxIdx] <= rxData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FRAME_BYTES; i++) wcMem[i] <= '0;
    end else if (strb.wcWr) begin
      wcMem[offset] <= mcuWdata;
    end
  end

  assign txData = wcMem[txIdx];

  always_comb begin
    rdVal = '0;
    unique case (region)
      REG_PER:  rdVal = bankMem[frontSel][offset];
      REG_DIAG: rdVal = diagMem[offset];
      REG_WC:   rdVal = wcMem[offset];
      REG_CTL:  if (offset == IDX_W'(CTL_STATUS)) rdVal[ST_W-1:0] = status;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            mcuRdata <= '0;
    else if (strb.rdEn) mcuRdata <= rdVal;
  end

endmodule

// File: rtl/bp_frame_cache.sv
module bp_frame_cache
  import bfc_pkg::*;
#(
  parameter  int FRAME_BYTES = 8,
  parameter  int DATA_W      = 8,
  parameter  int FREE_W      = 6,
  parameter  int CLASS_BIT   = 7,
  localparam int IDX_W       = $clog2(FRAME_BYTES),
  localparam int ADDR_W      = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxFrameRdy,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxPop,
  input  logic [FREE_W-1:0] txFree,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic              mcuWr,
  input  logic              mcuRd,
  input  logic [DATA_W-1:0] mcuWdata,
  output logic [DATA_W-1:0] mcuRdata,
  output logic              irq
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] rxIdx, txIdx;
  logic [ST_W-1:0]  status;

  bfc_ctrl #(
    .FRAME_BYTES(FRAME_BYTES), .FREE_W(FREE_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .rxFrameRdy(rxFrameRdy), .rxHdrClass(rxData[CLASS_BIT]),
    .rxPop(rxPop), .rxIdx(rxIdx),
    .txFree(txFree), .txPush(txPush), .txIdx(txIdx),
    .mcuAddr(mcuAddr), .mcuWr(mcuWr), .mcuRd(mcuRd),
    .lostClrBit(mcuWdata[ST_LOST]),
    .strb(strb), .status(status)
  );

  bfc_data #(
    .FRAME_BYTES(FRAME_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) data_i (
    .clk(clk), .rst(rst), .strb(strb),
    .rxIdx(rxIdx), .rxData(rxData),
    .txIdx(txIdx), .txData(txData),
    .mcuAddr(mcuAddr), .mcuWdata(mcuWdata),
    .status(status), .mcuRdata(mcuRdata)
  );

  assign irq = status[ST_DIAG];

endmodule

// File: rtl/bp_frame_cache_chk.sv
module bp_frame_cache_chk #(
  parameter int FRAME_BYTES = 8,
  parameter int FREE_W      = 6,
  parameter int ADDR_W      = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rxPop,
  input logic              irq,
  input logic              mcuRd,
  input logic [ADDR_W-1:0] mcuAddr,
  input logic              txPush,
  input logic [FREE_W-1:0] txFree
);

  localparam logic [ADDR_W-1:0] DIAG_LAST = ADDR_W'(2 * FRAME_BYTES - 1);
  localparam logic [FREE_W-1:0] FRAME_CNT = FREE_W'(FRAME_BYTES);

  // R4: irq only rises at the end of a frame transfer
  p_irq_after_pop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rxPop));

  // R5: the stored diagnostic frame is held until its last byte is read
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq && !(mcuRd && mcuAddr == DIAG_LAST)) |=> irq);

  // R6: reading the last diagnostic byte releases the area
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && mcuRd && mcuAddr == DIAG_LAST) |=> !irq);

  // R8: a push run starts only after room for a whole frame was seen
  p_tx_space_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(txPush) |-> ($past(txFree) >= FRAME_CNT));

endmodule

bind bp_frame_cache bp_frame_cache_chk #(
  .FRAME_BYTES(FRAME_BYTES), .FREE_W(FREE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .rxPop(rxPop), .irq(irq), .mcuRd(mcuRd),
  .mcuAddr(mcuAddr), .txPush(txPush), .txFree(txFree)
);

// File: tb/bp_frame_cache_tb.sv
module bp_frame_cache_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxFrameRdy = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxPop;
  logic [5:0] txFree = '0;
  logic       txPush;
  logic [7:0] txData;
  logic [4:0] mcuAddr = '0;
  logic       mcuWr = 1'b0;
  logic       mcuRd = 1'b0;
  logic [7:0] mcuWdata = '0;
  logic [7:0] mcuRdata;
  logic       irq;

  always #2 clk = ~clk;

  bp_frame_cache dut_i (
    .clk(clk), .rst(rst), .rxFrameRdy(rxFrameRdy), .rxData(rxData), .rxPop(rxPop),
    .txFree(txFree), .txPush(txPush), .txData(txData),
    .mcuAddr(mcuAddr), .mcuWr(mcuWr), .mcuRd(mcuRd), .mcuWdata(mcuWdata),
    .mcuRdata(mcuRdata), .irq(irq)
  );

  // behavioural reference state
  int visM[8], stgM[8], diagM[8], wcM[8];
  int diagFullM, lostM, txSt, txIdxM, rxBusyM, rxIdxM, rxTgtM, rdM;
  int rxQ[$];
  int pushedQ[$];
  int freeVar;
  int nChecks = 0, nFail = 0;
  string curReq = "R10";
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      visM[i] = 0; stgM[i] = 0; diagM[i] = 0; wcM[i] = 0;
    end
    diagFullM = 0; lostM = 0; txSt = 0; txIdxM = 0;
    rxBusyM = 0; rxIdxM = 0; rxTgtM = 0; rdM = 0;
  endtask

  task automatic cycle(bit wr, bit rd, int addr, int wdata);
    int region, off, rdNext, pop, b, clrDiag, setDiag, setLost;
    @(negedge clk);
    rxFrameRdy = (rxQ.size() >= 8);
    rxData     = (rxQ.size() > 0) ? 8'(rxQ[0]) : 8'h00;
    mcuWr = wr; mcuRd = rd; mcuAddr = 5'(addr); mcuWdata = 8'(wdata);
    txFree = 6'(freeVar);
    #1;
    if (rst) begin
      modelReset();
      return;
    end
    pop = (rxBusyM != 0 || rxFrameRdy) ? 1 : 0;
    check(curReq, "rxPop", int'(rxPop), pop);
    check(curReq, "txPush", int'(txPush), (txSt == 2) ? 1 : 0);
    if (txSt == 2) check(curReq, "txData", int'(txData), wcM[txIdxM]);
    check(curReq, "irq", int'(irq), diagFullM);
    check(curReq, "mcuRdata", int'(mcuRdata), rdM);
    if (txPush) pushedQ.push_back(int'(txData));

    region = addr >> 3; off = addr & 7;
    rdNext = rdM;
    if (rd) begin
      case (region)
        0: rdNext = visM[off];
        1: rdNext = diagM[off];
        2: rdNext = wcM[off];
        default: rdNext = (off == 0) ? (((txSt != 0) ? 4 : 0) | (lostM << 1) | diagFullM) : 0;
      endcase
    end
    clrDiag = (rd && addr == 15 && diagFullM != 0) ? 1 : 0;
    setDiag = 0; setLost = 0;
    if (pop != 0) begin
      b = rxQ.pop_front();
      if (rxBusyM == 0) begin
        rxIdxM = 0;
        rxTgtM = ((b & 128) == 0) ? 0 : ((diagFullM != 0) ? 2 : 1);
      end
      if (rxTgtM == 0) stgM[rxIdxM] = b;
      else if (rxTgtM == 1) diagM[rxIdxM] = b;
      if (rxIdxM == 7) begin
        if (rxTgtM == 0) for (int i = 0; i < 8; i++) visM[i] = stgM[i];
        if (rxTgtM == 1) setDiag = 1;
        if (rxTgtM == 2) setLost = 1;
        rxBusyM = 0;
      end else begin
        rxBusyM = 1;
        rxIdxM++;
      end
    end
    if (setDiag != 0) diagFullM = 1;
    else if (clrDiag != 0) diagFullM = 0;
    if (setLost != 0) lostM = 1;
    else if (wr && addr == 24 && (wdata & 2) != 0) lostM = 0;
    case (txSt)
      0: begin
        if (wr && region == 2) wcM[off] = wdata & 255;
        if (wr && addr == 25) txSt = 1;
      end
      1: if (freeVar >= 8) begin txSt = 2; txIdxM = 0; end
      default: if (txIdxM == 7) txSt = 0; else txIdxM++;
    endcase
    rdM = rdNext;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0);
  endtask

  task automatic rdExpect(int addr, int exp, string req);
    cycle(0, 1, addr, 0);
    cycle(0, 0, 0, 0);
    check(req, $sformatf("read addr %0d", addr), int'(mcuRdata), exp);
  endtask

  task automatic sendFrame(int hdr, int seed);
    rxQ.push_back(hdr);
    for (int i = 1; i < 8; i++) rxQ.push_back((seed + i) & 255);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    freeVar = 0;
    modelReset();
    idle(3);
    @(negedge clk); rst = 1'b0;
    curReq = "R10";
    check("R10", "reset irq", int'(irq), 0);
    check("R10", "reset txPush", int'(txPush), 0);
    check("R10", "reset rdata", int'(mcuRdata), 0);
    rdExpect(3, 0, "R10");

    // R1 / R2: periodic frames and replacement
    curReq = "R1";
    sendFrame(8'h05, 8'h10);
    idle(10);
    rdExpect(0, 8'h05, "R1");
    rdExpect(4, 8'h14, "R1");
    curReq = "R2";
    sendFrame(8'h22, 8'h40);
    idle(10);
    rdExpect(0, 8'h22, "R2");
    rdExpect(7, 8'h47, "R2");
    rdExpect(24, 0, "R2");
    check("R2", "irq after periodic", int'(irq), 0);

    // R3: reads during a transfer
    curReq = "R3";
    sendFrame(8'h33, 8'h60);
    for (int i = 0; i < 12; i++) cycle(0, 1, i % 8, 0);
    idle(1);
    rdExpect(1, 8'h61, "R3");

    // R4: diagnostic frame stored, irq
    curReq = "R4";
    sendFrame(8'h81, 8'h90);
    idle(10);
    check("R4", "irq after diag", int'(irq), 1);
    rdExpect(8, 8'h81, "R4");
    for (int i = 1; i < 7; i++) cycle(0, 1, 8 + i, 0);
    idle(1);
    check("R6", "irq kept after partial read", int'(irq), 1);

    // R5: second diagnostic dropped
    curReq = "R5";
    sendFrame(8'hC4, 8'hA0);
    sendFrame(8'h06, 8'h70);
    idle(20);
    rdExpect(8, 8'h81, "R5");
    rdExpect(12, 8'h94, "R5");
    rdExpect(24, 3, "R5");
    rdExpect(0, 8'h06, "R5");

    // R6: clearing read
    curReq = "R6";
    cycle(0, 1, 15, 0);
    idle(1);
    check("R6", "irq after last byte read", int'(irq), 0);
    check("R6", "last byte value", int'(mcuRdata), 8'h97);

    // R7: lost flag clear
    curReq = "R7";
    cycle(1, 0, 24, 8'h01);
    rdExpect(24, 2, "R7");
    cycle(1, 0, 24, 8'h02);
    rdExpect(24, 0, "R7");

    // R8 / R9: write cache and commit
    curReq = "R8";
    for (int i = 0; i < 8; i++) cycle(1, 0, 16 + i, 8'hB0 + i);
    freeVar = 3;
    cycle(1, 0, 25, 0);
    rdExpect(24, 4, "R8");
    curReq = "R9";
    cycle(1, 0, 16, 8'hEE);
    cycle(1, 0, 25, 0);
    idle(4);
    check("R8", "no push without room", pushedQ.size(), 0);
    curReq = "R8";
    freeVar = 8;
    idle(14);
    check("R8", "push count", pushedQ.size(), 8);
    for (int i = 0; i < 8; i++)
      if (i < pushedQ.size()) check("R8", $sformatf("pushed byte %0d", i), pushedQ[i], 8'hB0 + i);
    rdExpect(24, 0, "R8");
    rdExpect(16, 8'hB0, "R9");
    idle(6);
    check("R9", "no second push", pushedQ.size(), 8);

    // R10: back-to-back frames of both classes
    curReq = "R10";
    sendFrame(8'h11, 8'h20);
    sendFrame(8'h85, 8'h50);
    idle(20);
    rdExpect(2, 8'h22, "R10");
    rdExpect(9, 8'h51, "R10");
    check("R4", "irq after back-to-back diag", int'(irq), 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule